// File: doc/BRIEF.md
# Serial Command Slave for a 7-Bit Setting Register

This block is a two-wire serial bus slave that owns one 7-bit setting, such as a panel bias code. It samples the bus clock and data lines with a fast system clock, cleans them with a synchronizer and a glitch filter, and recognises START and STOP conditions. It responds only to its fixed 7-bit device address. A write frame carries one command byte. The upper seven bits of that byte are the new code. The low bit chooses where the code goes: to the live register, or to a nonvolatile store that a separate manager block runs.

The slave asks that manager, through `store_ready`, whether a store write can be taken right now. The manager answers no while a previous write is still being programmed and once every slot has been used. A store-bound command that is refused gets a NACK on the data byte and is dropped. A read frame returns the live code in the upper seven bits of the byte. The data line is driven only as an open-drain pull-down enable.

Top module: `vcom_i2c_cmd_slave`

## Requirements
- R1: After reset, `live_code` equals RESET_CODE (default 0x40), `sda_oe` is 0 and `store_wr` is 0.
- R2: The slave acknowledges an address byte whose upper seven bits are DEV_ADDR (default 1001111b). This gives 0x9E for a write and 0x9F for a read, with bit 0 = 1 meaning read. The ACK holds SDA low for the whole ninth SCL pulse.
- R3: A write data byte whose bit 0 is 1 is acknowledged. After that ACK pulse ends, bits 7:1 of the byte load `live_code`.
- R4: A read returns one byte, MSB first. Bits 7:1 hold `live_code` and bit 0 is sent as 0.
- R5: A write data byte whose bit 0 is 0 is acknowledged when `store_ready` is 1. After the ACK pulse, `store_wr` pulses for exactly one cycle with `store_code` set to bits 7:1. `live_code` is not changed.
- R6: A write data byte whose bit 0 is 0 is NACKed when `store_ready` is 0. No store write follows and `live_code` is unchanged.
- R7: An address byte that does not match is not acknowledged. The slave stays released and ignores every later bit until the next START.
- R8: A STOP received before the data byte has been fully received and acknowledged discards the command.
- R9: A repeated START restarts address reception, and the frame that follows it takes effect.
- R10: Pulses on SCL or SDA shorter than FILT system clocks do not disturb a transfer. With the defaults, 8 cycles (40 ns) is filtered out.
- R11: `sda_oe` changes only while the filtered SCL is low, so read data and ACK stay stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line, as seen on the wire |
| store_ready | input | 1 | Store manager can take a write now |
| sda_oe | output | 1 | 1 pulls the data line low |
| store_wr | output | 1 | One-cycle store write request |
| store_code | output | CODE_W | Code sent with the store write request |
| live_code | output | CODE_W | Live setting register |

## Verification
Every bus line change reaches the control logic 3 + FILT system clocks later. That is two synchronizer flops, the FILT-long filter window and one edge-detect flop, so 15 cycles with the defaults. A register update or a `store_wr` pulse comes one cycle after the filtered SCL falls at the end of the ACK pulse. A change on `sda_oe` comes one cycle after a filtered SCL fall.

The bench master holds each quarter bit phase for 40 cycles, which is much longer than this latency. It samples the line in the middle of the SCL-high phase and checks `live_code` only after the STOP. Store requests are predicted by a driver task, which pushes each expected code into a queue. A negedge monitor pops the queue on each `store_wr` and flags any pulse that was not expected.

// File: rtl/vcom_i2c_cmd_slave.sv
module vcom_i2c_cmd_slave #(
  parameter int          CODE_W     = 7,
  parameter logic [6:0]  DEV_ADDR   = 7'b1001111,
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(64),
  parameter int          FILT       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              store_ready,
  output logic              sda_oe,
  output logic              store_wr,
  output logic [CODE_W-1:0] store_code,
  output logic [CODE_W-1:0] live_code
);
  localparam int BW    = CODE_W + 1;
  localparam int CNT_W = $clog2(BW + 1);
  localparam int FC_W  = $clog2(FILT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BW);
  localparam logic [FC_W-1:0]  FLIM = FC_W'(FILT - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDATA, S_DACK, S_RDATA, S_RACK} st_t;

  logic [1:0] raw, s1, s2, flt, flt_d;
  assign raw = {scl_i, sda_i};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [FC_W-1:0] fc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[i] <= 1'b1; s2[i] <= 1'b1; flt[i] <= 1'b1; flt_d[i] <= 1'b1; fc <= '0;
      end else begin
        s1[i] <= raw[i];
        s2[i] <= s1[i];
        flt_d[i] <= flt[i];
        if (s2[i] == flt[i]) fc <= '0;
        else if (fc == FLIM) begin flt[i] <= s2[i]; fc <= '0; end
        else fc <= fc + 1'b1;
      end
    end
  end

  logic scl_f, sda_f, start_ev, stop_ev, scl_rise, scl_fall;
  assign scl_f    = flt[1];
  assign sda_f    = flt[0];
  assign start_ev = scl_f & flt_d[1] & flt_d[0] & ~sda_f;
  assign stop_ev  = scl_f & flt_d[1] & ~flt_d[0] & sda_f;
  assign scl_rise = scl_f & ~flt_d[1];
  assign scl_fall = ~scl_f & flt_d[1];

  st_t             st;
  logic [CNT_W-1:0] bcnt;
  logic [BW-1:0]   sh;
  logic            rd, take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; rd <= 1'b0; take <= 1'b0;
      sda_oe <= 1'b0; store_wr <= 1'b0; store_code <= '0; live_code <= RESET_CODE;
    end else begin
      store_wr <= 1'b0;
      if (start_ev) begin
        st <= S_ADDR; bcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (st == S_ADDR || st == S_WDATA) begin
          sh <= {sh[BW-2:0], sda_f}; bcnt <= bcnt + 1'b1;
        end else if (st == S_RDATA) bcnt <= bcnt + 1'b1;
      end else if (scl_fall) begin
        case (st)
          S_ADDR: if (bcnt == LAST) begin
            if (sh[BW-1:1] == DEV_ADDR) begin st <= S_AACK; sda_oe <= 1'b1; rd <= sh[0]; end
            else st <= S_IDLE;
          end
          S_AACK: begin
            bcnt <= '0;
            if (rd) begin st <= S_RDATA; sh <= {live_code, 1'b0}; sda_oe <= ~live_code[CODE_W-1]; end
            else begin st <= S_WDATA; sda_oe <= 1'b0; end
          end
          S_WDATA: if (bcnt == LAST) begin
            st <= S_DACK; take <= sh[0] | store_ready; sda_oe <= sh[0] | store_ready;
          end
          S_DACK: begin
            st <= S_IDLE; sda_oe <= 1'b0;
            if (take) begin
              if (sh[0]) live_code <= sh[BW-1:1];
              else begin store_wr <= 1'b1; store_code <= sh[BW-1:1]; end
            end
          end
          S_RDATA: if (bcnt == LAST) begin sda_oe <= 1'b0; st <= S_RACK; end
                   else begin sh <= {sh[BW-2:0], 1'b0}; sda_oe <= ~sh[BW-2]; end
          S_RACK: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vcom_i2c_cmd_slave_chk.sv
module vcom_i2c_cmd_slave_chk #(parameter int CODE_W = 7) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic [2:0]        st,
  input logic              sda_oe,
  input logic              store_wr,
  input logic [CODE_W-1:0] live_code
);
  p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);
  p_oe_steady_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));
  p_store_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr |=> !store_wr);
  p_store_keeps_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr |-> $stable(live_code));
endmodule

bind vcom_i2c_cmd_slave vcom_i2c_cmd_slave_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .st(st), .sda_oe(sda_oe),
  .store_wr(store_wr), .live_code(live_code));

// File: tb/sim_vcom_i2c_cmd_slave.sv
`timescale 1ns/1ps
module sim_vcom_i2c_cmd_slave;
  localparam int Q = 40;
  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, store_ready = 1;
  logic sda_oe, store_wr, sda_line;
  logic [6:0] store_code, live_code;
  int nchk = 0, nerr = 0;
  logic [6:0] q[$];
  logic [6:0] exp_live;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  vcom_i2c_cmd_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .store_ready(store_ready), .sda_oe(sda_oe), .store_wr(store_wr),
    .store_code(store_code), .live_code(live_code));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  always @(negedge clk) if (rst_n && store_wr) begin
    if (q.size() == 0) chk(0, "R6 unexpected store write", store_code, 0);
    else begin
      logic [6:0] e;
      e = q.pop_front();
      chk(store_code == e, "R5 store code", store_code, e);
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic start_c(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic stop_c(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic send_bit(input bit b, input bit glitch);
    sda_m = b; wq(); scl_m = 1;
    if (glitch) begin
      repeat (10) @(negedge clk);
      sda_m = 0; repeat (8) @(negedge clk); sda_m = b;
      repeat (10) @(negedge clk);
      scl_m = 0; repeat (8) @(negedge clk); scl_m = 1;
    end else wq();
    wq(); scl_m = 0; wq();
  endtask
  task automatic wbyte(input logic [7:0] v, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && i == 7);
    sda_m = 1; wq(); scl_m = 1; wq(); ack = !sda_line; wq(); scl_m = 0; wq();
  endtask
  task automatic rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic a, b;
      sda_m = 1; wq(); scl_m = 1; repeat (Q/2) @(negedge clk); a = sda_line;
      repeat (Q/2) @(negedge clk); v[i] = sda_line;
      repeat (Q - 2) @(negedge clk); b = sda_line;
      chk(a == v[i] && b == v[i], "R11 data stable while SCL high", {a, b}, {v[i], v[i]});
      repeat (2) @(negedge clk); scl_m = 0; wq();
    end
    sda_m = 1; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
  endtask

  task automatic do_write(input logic [6:0] code, input bit m, input bit glitch,
                          input bit exp_dack, input string tag);
    bit a;
    start_c();
    wbyte(8'h9E, glitch, a); chk(a, {tag, " address ACK"}, a, 1);
    wbyte({code, m}, 1'b0, a); chk(a == exp_dack, {tag, " data ACK"}, a, exp_dack);
    stop_c();
    chk(live_code == exp_live, {tag, " live code"}, live_code, exp_live);
  endtask

  task automatic do_read(input string tag);
    bit a; logic [7:0] v;
    start_c();
    wbyte(8'h9F, 1'b0, a); chk(a, "R2 read address ACK", a, 1);
    rbyte(v);
    stop_c();
    chk(v == {exp_live, 1'b0}, tag, v, {exp_live, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    bit a;
    repeat (5) @(negedge clk); rst_n = 1; @(negedge clk);
    chk(live_code == 7'h40 && !sda_oe && !store_wr, "R1 reset state", {store_wr, sda_oe, live_code}, 7'h40);
    exp_live = 7'h40;
    wq();
    do_read("R4 R1 read of reset code");
    exp_live = 7'h25; do_write(7'h25, 1, 0, 1, "R3");
    do_read("R4 read after live write");
    q.push_back(7'h5A); do_write(7'h5A, 0, 0, 1, "R5");
    store_ready = 0; do_write(7'h33, 0, 0, 0, "R6");
    store_ready = 1;
    // R7 wrong address
    start_c();
    wbyte(8'h90, 1'b0, a); chk(!a, "R7 foreign address NACK", a, 0);
    wbyte({7'h0F, 1'b1}, 1'b0, a); chk(!a, "R7 later byte ignored", a, 0);
    stop_c();
    chk(live_code == exp_live, "R7 live code kept", live_code, exp_live);
    // R8 early stop
    start_c();
    wbyte(8'h9E, 1'b0, a); chk(a, "R8 address ACK", a, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    stop_c();
    chk(live_code == exp_live, "R8 aborted command dropped", live_code, exp_live);
    // R9 repeated start
    start_c();
    wbyte(8'h9E, 1'b0, a);
    start_c();
    wbyte(8'h9E, 1'b0, a); chk(a, "R9 address ACK after repeated START", a, 1);
    wbyte({7'h11, 1'b1}, 1'b0, a); chk(a, "R9 data ACK", a, 1);
    stop_c();
    exp_live = 7'h11;
    chk(live_code == exp_live, "R9 live code", live_code, exp_live);
    // R10 glitches
    exp_live = 7'h6C; do_write(7'h6C, 1, 1, 1, "R10");
    do_read("R4 read after glitch frame");
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R5 pending store writes", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule